// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit sits between instruction decode and execution. For each accepted request it takes a 4-bit mode code, an address field A, a register selector R and an indirection depth. It works out the effective address (EA) and returns the operand. Depending on the mode, it makes zero, one, two or more reads on a single-port synchronous memory. It reads register R through a combinational register-file port and reads the current program counter. In two modes it can also produce one register write-back: an auto-increment of the index, or an update of the base register with the computed address.

The unit accepts a request with `start` while it is idle. It captures all of its inputs in that cycle. It then walks a state sequence that depends on the mode. IDLE goes to PTR_ISSUE for pointer-chasing modes, to OPR_ISSUE for single-read modes, or straight to FINISH for modes with no memory access or an illegal code. PTR_ISSUE always goes to PTR_TAKE. PTR_TAKE loops back to PTR_ISSUE while pointer levels remain, and otherwise goes to OPR_ISSUE. OPR_ISSUE goes to OPR_TAKE, OPR_TAKE goes to FINISH, and FINISH returns to IDLE.

Each memory read takes two cycles. The request and address are driven in an ISSUE state, and the data returned one cycle later is captured in the matching TAKE state. All addition wraps modulo 2^W.

Top module: `opfetch_unit`

## Requirements
- R1: Mode code 0 (immediate) returns A as the operand, reports EA 0 and issues no memory read.
- R2: Mode code 3 (register) returns the contents of register R, reports EA 0 and issues no memory read.
- R3: Mode code 1 (direct) uses EA = A. Mode code 4 (register indirect) uses EA = (R). Each makes exactly one memory read, and the operand is the word read at EA.
- R4: Mode code 2 (indirect) first reads a pointer at A. It then follows pointers for `nest` further levels, with `nest` capped at MAXNEST. The last pointer is the EA, and one more read at EA fetches the operand, so nest+2 reads in total.
- R5: Mode code 5 (displacement) uses EA = A + (R). Mode code 6 (PC-relative) uses EA = A + PC. The sum wraps modulo 2^W, and each mode makes one read.
- R6: Mode code 7 (indexed) uses EA = A + (R) with one read. When `upd` is 1, it writes (R)+1 to register R.
- R7: Mode code 5 with `upd` = 1 writes the computed EA back to register R (base update).
- R8: Mode code 8 (pre-index) uses EA = mem[A + (R)]. Mode code 9 (post-index) uses EA = mem[A] + (R). Each then reads the operand at EA, for two reads in total.
- R9: Mode codes 10 to 15 raise `illegal` together with `done`, return operand 0 and EA 0, and issue no memory read and no write-back.
- R10: Each memory request lasts one cycle, and its data is taken in the cycle that follows. `done` is a one-cycle pulse that arrives exactly 1 + 2·(number of reads) cycles after the accepting edge.
- R11: `busy` is high from acceptance through the `done` cycle. A `start` seen while busy is ignored and does not change the result.
- R12: After reset `busy`, `done`, `mem_req`, `wb_en` and `illegal` are low, and `operand` and `ea` are 0.
- R13: `wb_en` is high only during the `done` cycle. It is high only for modes 5 and 7, and only when `upd` = 1, so every other request leaves the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 4 | Addressing mode code |
| afield | input | W | Address field A |
| rsel | input | RW | Register selector R |
| nest | input | NW | Extra indirection levels for mode 2 |
| upd | input | 1 | Enable write-back in modes 5 and 7 |
| rf_addr | output | RW | Register-file read index |
| rf_data | input | W | Register-file read data (combinational) |
| pc | input | W | Current program counter |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | W | Memory read address |
| mem_rdata | input | W | Memory read data, valid one cycle after request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unused mode code, valid with done |
| operand | output | W | Fetched operand, held after done |
| ea | output | W | Effective address, held after done |
| wb_en | output | 1 | Register write-back strobe |
| wb_sel | output | RW | Register index for the write-back |
| wb_data | output | W | Write-back value |

## Verification
The bound checker covers the handshake on every cycle. It checks that `done` lasts one cycle, that `busy` covers acceptance through `done`, that no request or completion appears while idle, and that every memory request lasts one cycle. It also checks that `wb_en` and `illegal` only appear with `done`. Only the bench scenarios can show the per-mode arithmetic: the operand and EA values, wrap-around of the sums, the number of reads and pointer levels, the exact completion latency, and register-file contents after write-back or non-write-back. The bench sweeps every mode code against several address fields, all registers, every nest depth and both `upd` settings. It computes expected results from a closed-form memory content function.

// File: rtl/opf_pkg.sv
package opf_pkg;

    localparam logic [3:0] MD_IMM  = 4'd0;
    localparam logic [3:0] MD_DIR  = 4'd1;
    localparam logic [3:0] MD_IND  = 4'd2;
    localparam logic [3:0] MD_REG  = 4'd3;
    localparam logic [3:0] MD_RIND = 4'd4;
    localparam logic [3:0] MD_DISP = 4'd5;
    localparam logic [3:0] MD_REL  = 4'd6;
    localparam logic [3:0] MD_IDX  = 4'd7;
    localparam logic [3:0] MD_PRE  = 4'd8;
    localparam logic [3:0] MD_POST = 4'd9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_ISSUE,
        S_PTR_TAKE,
        S_OPR_ISSUE,
        S_OPR_TAKE,
        S_FINISH
    } fetch_state_t;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_PTR,
        PATH_OPR
    } path_t;

endpackage

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
    import opf_pkg::*;
#(
    parameter int W       = 8,
    parameter int MAXNEST = 3,
    parameter int NW      = 2,
    parameter int CW      = 3
) (
    input  logic [3:0]    mode,
    input  logic [W-1:0]  afield,
    input  logic [W-1:0]  rv,
    input  logic [W-1:0]  pc,
    input  logic [NW-1:0] nest,
    input  logic          upd,
    output path_t         path,
    output logic [W-1:0]  first_addr,
    output logic [CW-1:0] ptr_cnt,
    output logic          post,
    output logic [W-1:0]  nomem_val,
    output logic          bad,
    output logic          wb_req,
    output logic [W-1:0]  wb_val
);

    logic [W-1:0]  a_plus_r;
    logic [W-1:0]  a_plus_pc;
    logic [NW-1:0] nest_eff;
    logic [CW-1:0] ind_levels;

    assign a_plus_r   = afield + rv;
    assign a_plus_pc  = afield + pc;
    assign nest_eff   = (32'(nest) > MAXNEST) ? NW'(MAXNEST) : nest;
    assign ind_levels = CW'(nest_eff) + CW'(1);

    always_comb begin
        path       = PATH_NONE;
        first_addr = '0;
        ptr_cnt    = CW'(1);
        post       = 1'b0;
        nomem_val  = '0;
        bad        = 1'b0;
        wb_req     = 1'b0;
        wb_val     = '0;
        case (mode)
            MD_IMM: begin
                nomem_val = afield;
            end
            MD_REG: begin
                nomem_val = rv;
            end
            MD_DIR: begin
                path       = PATH_OPR;
                first_addr = afield;
            end
            MD_IND: begin
                path       = PATH_PTR;
                first_addr = afield;
                ptr_cnt    = ind_levels;
            end
            MD_RIND: begin
                path       = PATH_OPR;
                first_addr = rv;
            end
            MD_DISP: begin
                path       = PATH_OPR;
                first_addr = a_plus_r;
                wb_req     = upd;
                wb_val     = a_plus_r;
            end
            MD_REL: begin
                path       = PATH_OPR;
                first_addr = a_plus_pc;
            end
            MD_IDX: begin
                path       = PATH_OPR;
                first_addr = a_plus_r;
                wb_req     = upd;
                wb_val     = rv + W'(1);
            end
            MD_PRE: begin
                path       = PATH_PTR;
                first_addr = a_plus_r;
            end
            MD_POST: begin
                path       = PATH_PTR;
                first_addr = afield;
                post       = 1'b1;
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/opf_fsm.sv
module opf_fsm
    import opf_pkg::*;
#(
    parameter int W  = 8,
    parameter int RW = 2,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  path_t         path,
    input  logic [W-1:0]  first_addr,
    input  logic [CW-1:0] ptr_cnt,
    input  logic          post,
    input  logic [W-1:0]  nomem_val,
    input  logic          bad,
    input  logic          wb_req,
    input  logic [W-1:0]  wb_val,
    input  logic [W-1:0]  rv,
    input  logic [RW-1:0] rsel,
    input  logic [W-1:0]  mem_rdata,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [W-1:0]  operand,
    output logic [W-1:0]  ea,
    output logic          wb_en,
    output logic [RW-1:0] wb_sel,
    output logic [W-1:0]  wb_data
);

    fetch_state_t  st, st_nx;
    logic          accept;
    logic [W-1:0]  addr_q;
    logic [CW-1:0] cnt_q;
    logic          post_q;
    logic [W-1:0]  rv_q;
    logic          ill_q;
    logic          wbr_q;
    logic [RW-1:0] wbs_q;
    logic [W-1:0]  wbd_q;
    logic [W-1:0]  opnd_q;
    logic [W-1:0]  ea_q;

    assign accept = (st == S_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    unique case (path)
                        PATH_PTR: st_nx = S_PTR_ISSUE;
                        PATH_OPR: st_nx = S_OPR_ISSUE;
                        default:  st_nx = S_FINISH;
                    endcase
                end
            end
            S_PTR_ISSUE: st_nx = S_PTR_TAKE;
            S_PTR_TAKE:  st_nx = (cnt_q == CW'(1)) ? S_OPR_ISSUE : S_PTR_ISSUE;
            S_OPR_ISSUE: st_nx = S_OPR_TAKE;
            S_OPR_TAKE:  st_nx = S_FINISH;
            S_FINISH:    st_nx = S_IDLE;
            default:     st_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            post_q <= 1'b0;
            rv_q   <= '0;
            ill_q  <= 1'b0;
            wbr_q  <= 1'b0;
            wbs_q  <= '0;
            wbd_q  <= '0;
            opnd_q <= '0;
            ea_q   <= '0;
        end else begin
            if (accept) begin
                addr_q <= first_addr;
                cnt_q  <= ptr_cnt;
                post_q <= post;
                rv_q   <= rv;
                ill_q  <= bad;
                wbr_q  <= wb_req;
                wbs_q  <= rsel;
                wbd_q  <= wb_val;
                if (path == PATH_NONE) begin
                    opnd_q <= nomem_val;
                    ea_q   <= '0;
                end
            end
            if (st == S_PTR_TAKE) begin
                addr_q <= mem_rdata + (post_q ? rv_q : '0);
                cnt_q  <= cnt_q - CW'(1);
            end
            if (st == S_OPR_TAKE) begin
                opnd_q <= mem_rdata;
                ea_q   <= addr_q;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req  = (st == S_PTR_ISSUE) || (st == S_OPR_ISSUE);
        mem_addr = addr_q;
        busy     = (st != S_IDLE);
        done     = (st == S_FINISH);
        illegal  = done && ill_q;
        wb_en    = done && wbr_q;
        wb_sel   = wbs_q;
        wb_data  = wbd_q;
        operand  = opnd_q;
        ea       = ea_q;
    end

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
    import opf_pkg::*;
#(
    parameter  int W       = 8,
    parameter  int RW      = 2,
    parameter  int MAXNEST = 3,
    localparam int NW      = (MAXNEST < 1) ? 1 : $clog2(MAXNEST + 1),
    localparam int CW      = $clog2(MAXNEST + 2) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [W-1:0]  afield,
    input  logic [RW-1:0] rsel,
    input  logic [NW-1:0] nest,
    input  logic          upd,
    output logic [RW-1:0] rf_addr,
    input  logic [W-1:0]  rf_data,
    input  logic [W-1:0]  pc,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    input  logic [W-1:0]  mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [W-1:0]  operand,
    output logic [W-1:0]  ea,
    output logic          wb_en,
    output logic [RW-1:0] wb_sel,
    output logic [W-1:0]  wb_data
);

    path_t         g_path;
    logic [W-1:0]  g_first;
    logic [CW-1:0] g_cnt;
    logic          g_post;
    logic [W-1:0]  g_nomem;
    logic          g_bad;
    logic          g_wbreq;
    logic [W-1:0]  g_wbval;

    assign rf_addr = rsel;

    opf_addr_gen #(.W(W), .MAXNEST(MAXNEST), .NW(NW), .CW(CW)) u_gen (
        .mode       (mode),
        .afield     (afield),
        .rv         (rf_data),
        .pc         (pc),
        .nest       (nest),
        .upd        (upd),
        .path       (g_path),
        .first_addr (g_first),
        .ptr_cnt    (g_cnt),
        .post       (g_post),
        .nomem_val  (g_nomem),
        .bad        (g_bad),
        .wb_req     (g_wbreq),
        .wb_val     (g_wbval)
    );

    opf_fsm #(.W(W), .RW(RW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .path       (g_path),
        .first_addr (g_first),
        .ptr_cnt    (g_cnt),
        .post       (g_post),
        .nomem_val  (g_nomem),
        .bad        (g_bad),
        .wb_req     (g_wbreq),
        .wb_val     (g_wbval),
        .rv         (rf_data),
        .rsel       (rsel),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (done),
        .illegal    (illegal),
        .operand    (operand),
        .ea         (ea),
        .wb_en      (wb_en),
        .wb_sel     (wb_sel),
        .wb_data    (wb_data)
    );

endmodule

// File: rtl/opf_chk.sv
module opf_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic illegal,
    input logic mem_req,
    input logic wb_en
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r11_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));

    a_r9_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wb_en));

    a_r13_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

endmodule

bind opfetch_unit opf_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .mem_req (mem_req),
    .wb_en   (wb_en)
);

// File: tb/sim_opfetch_unit.sv
module sim_opfetch_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int RW         = 2;
    localparam int MAXNEST    = 3;
    localparam int NW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [W-1:0]  afield = '0;
    logic [RW-1:0] rsel = '0;
    logic [NW-1:0] nest = '0;
    logic          upd = 1'b0;
    logic [RW-1:0] rf_addr;
    logic [W-1:0]  rf_data;
    logic [W-1:0]  pc = '0;
    logic          mem_req;
    logic [W-1:0]  mem_addr;
    logic [W-1:0]  mem_rdata = '0;
    logic          busy, done, illegal, wb_en;
    logic [W-1:0]  operand, ea, wb_data;
    logic [RW-1:0] wb_sel;

    logic [W-1:0]  regs [4];
    int            rd_cnt = 0;
    int            n_chk = 0;
    int            n_fail = 0;

    opfetch_unit #(.W(W), .RW(RW), .MAXNEST(MAXNEST)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .afield(afield),
        .rsel(rsel), .nest(nest), .upd(upd), .rf_addr(rf_addr), .rf_data(rf_data),
        .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .illegal(illegal), .operand(operand), .ea(ea),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] memf(input logic [W-1:0] x);
        return x * 8'd37 + 8'd11;
    endfunction

    assign rf_data = regs[rf_addr];

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= memf(mem_addr);
            rd_cnt    <= rd_cnt + 1;
        end
        if (wb_en) regs[wb_sel] <= wb_data;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic init_regs(input logic [W-1:0] pcv);
        for (int i = 0; i < 4; i++) regs[i] = 8'h13 + 8'(i) * 8'h5A;
        pc = pcv;
    endtask

    task automatic run(input int m, input int a, input int r, input int n, input int u);
        logic [W-1:0] av, rv, p, e_op, e_ea;
        logic [W-1:0] er [4];
        int           e_ill, e_rd, lat;
        string        tag;
        av = 8'(a);
        init_regs(av ^ 8'h9C);
        rv = regs[r];
        for (int i = 0; i < 4; i++) er[i] = regs[i];
        e_ill = 0; e_rd = 1; e_ea = '0; tag = "R9";
        case (m)
            0: begin tag = "R1"; e_rd = 0; e_op = av; end
            3: begin tag = "R2"; e_rd = 0; e_op = rv; end
            1: begin tag = "R3"; e_ea = av; end
            4: begin tag = "R3"; e_ea = rv; end
            2: begin
                tag = "R4"; p = av;
                for (int k = 0; k <= n; k++) p = memf(p);
                e_ea = p; e_rd = n + 2;
            end
            5: begin tag = "R5"; e_ea = av + rv; if (u != 0) er[r] = av + rv; end
            6: begin tag = "R5"; e_ea = av + (av ^ 8'h9C); end
            7: begin tag = "R6"; e_ea = av + rv; if (u != 0) er[r] = rv + 8'd1; end
            8: begin tag = "R8"; e_ea = memf(av + rv); e_rd = 2; end
            9: begin tag = "R8"; e_ea = memf(av) + rv; e_rd = 2; end
            default: begin e_ill = 1; e_rd = 0; e_op = '0; end
        endcase
        if (e_rd > 0) e_op = memf(e_ea);
        rd_cnt = 0;
        mode = 4'(m); afield = av; rsel = 2'(r); nest = 2'(n); upd = u[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(tag, "operand", int'(operand), int'(e_op));
        chk(tag, "ea", int'(ea), int'(e_ea));
        chk("R9", "illegal", int'(illegal), e_ill);
        chk(tag, "reads", rd_cnt, e_rd);
        chk("R10", "latency", lat, 1 + 2 * e_rd);
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk((m == 5 && u != 0) ? "R7" : (m == 7 && u != 0) ? "R6" : "R13",
                "regfile", int'(regs[i]), int'(er[i]));
        chk("R11", "busy after done", int'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        init_regs(8'h00);
        repeat (3) @(negedge clk);
        chk("R12", "busy at reset", int'(busy), 0);
        chk("R12", "done at reset", int'(done), 0);
        chk("R12", "mem_req at reset", int'(mem_req), 0);
        chk("R12", "wb_en at reset", int'(wb_en), 0);
        chk("R12", "illegal at reset", int'(illegal), 0);
        chk("R12", "operand at reset", int'(operand), 0);
        chk("R12", "ea at reset", int'(ea), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 16; m++)
            for (int ai = 0; ai < 4; ai++)
                for (int r = 0; r < 4; r++)
                    for (int u = 0; u < 2; u++) begin
                        int a;
                        a = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h35 : (ai == 2) ? 8'hC8 : 8'hFF;
                        if (m == 2) begin
                            for (int n = 0; n <= MAXNEST; n++) run(m, a, r, n, u);
                        end else begin
                            run(m, a, r, 0, u);
                        end
                    end

        // R11: start held during busy is ignored
        init_regs(8'h00);
        mode = 4'd1; afield = 8'h40; rsel = '0; nest = '0; upd = 1'b0;
        start = 1'b1;
        @(negedge clk);
        mode = 4'd0; afield = 8'h11;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R11", "done after busy start", int'(done), 1);
        chk("R11", "operand ignores busy start", int'(operand), int'(memf(8'h40)));
        chk("R11", "ea ignores busy start", int'(ea), 32'h40);
        @(negedge clk);
        chk("R11", "no second done", int'(done), 0);
        @(negedge clk);
        chk("R11", "idle after", int'(busy), 0);

        summary();
        $finish;
    end

endmodule